// File: doc/BRIEF.md
# BCH Error Location Bit Corrector

This block applies the error positions reported by a BCH decoder to one data unit held in a byte-wide buffer that sits outside it. A start pulse hands over the decoder status, the number of reported errors and the selected correction strength. The error positions are read from a bank of 32-bit words through an index/data port. Each word packs two 13-bit bit positions. The block visits one position per clock. For every position that lands inside the data unit, it does a read-modify-write of the addressed byte that flips exactly one bit.

A position whose byte index is at or past the data-unit size points into the parity bytes. It is skipped: nothing is written and it is not counted. When correction ends, a one-cycle done pulse reports the number of bits actually flipped and whether the unit was uncorrectable. An uncorrectable or error-free status finishes at once and leaves the buffer untouched. The block also shows how many parity bytes the selected strength implies.

Top module: `bch_bit_fixer`

## Requirements
- R1: After reset, `done`, `busy` and `buf_we` are 0 and `flip_count` is 0.
- R2: Location word k carries error position 2k in bits 12:0 and error position 2k+1 in bits 28:16. All other bits of the word are ignored. Positions are visited in ascending order, one per clock, starting in the cycle after `start` is accepted. `loc_idx` selects the word being read.
- R3: For a visited position p, the byte index is p/8 and the bit index is p mod 8. The block writes `buf_rdata ^ (1 << (p mod 8))` to byte p/8, so exactly one bit of that byte changes.
- R4: A position whose byte index is not below UNIT_BYTES still takes its clock cycle. It causes no write and is not counted.
- R5: With N errors, ceil(N/2) words are read. When N is odd, the upper field of the last word is never applied.
- R6: The strength select `t_sel` takes the values 8, 16, 24 and 40. Any other value acts as 16. An error count above the effective strength is limited to it.
- R7: `parity_bytes` equals 13 × (effective strength / 8), that is 13, 26, 39 or 65.
- R8: The status encoding is 2'b00 no error, 2'b01 correctable and 2'b10 uncorrectable; 2'b11 is treated as uncorrectable. Only a correctable status causes writes. For an uncorrectable status, `done` rises in the cycle after start with `uncorrectable`=1 and `flip_count`=0, and the buffer is unchanged. For no error, the same timing applies with `uncorrectable`=0.
- R9: `done` is a one-cycle pulse in the cycle after the last visited position. A correctable status with a zero error count gives `done` in the cycle after start. `flip_count` then equals the number of writes made, and `busy` is high exactly while positions are being visited.
- R10: A `start` pulse that arrives while `busy` is high is ignored, and the running correction completes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin processing one data unit |
| dec_status | input | 2 | Decoder verdict, sampled with start |
| err_count | input | 6 | Number of reported error positions, sampled with start |
| t_sel | input | 6 | Correction strength select, sampled with start |
| loc_idx | output | 5 | Index of the location word being read |
| loc_word | input | 32 | Location word at `loc_idx`, same cycle |
| buf_addr | output | log2(UNIT_BYTES) | Byte address of the buffer port |
| buf_rdata | input | 8 | Buffer byte at `buf_addr`, same cycle |
| buf_we | output | 1 | Buffer write enable |
| buf_wdata | output | 8 | Corrected byte to write |
| busy | output | 1 | Positions are being visited |
| done | output | 1 | One-cycle completion pulse |
| uncorrectable | output | 1 | Unit was not correctable, valid with done |
| flip_count | output | 6 | Bits flipped, valid with done |
| parity_bytes | output | 7 | Parity bytes per unit at the current strength |

## Verification
The bench builds the block with UNIT_BYTES=64, so the data unit covers only bit positions 0 to 511. Random 13-bit positions therefore land both inside the unit and in the skipped parity range, and the skip path is exercised in most runs. The location words carry set bits in the unused fields, and several runs use an odd error count with an in-range position placed in the unused upper half. Strength selects of 40 and above-limit counts drive the visit counter to its full and clamped extremes.

// File: rtl/bchfix_pkg.sv
package bchfix_pkg;

  localparam int CNT_W   = 6;   // holds the largest strength, 40
  localparam int POS_W   = 13;  // width of one bit-position field
  localparam int HI_LSB  = 16;  // start of the second field in a word
  localparam int WIDX_W  = 5;   // word index: up to 20 words
  localparam int PLEN_W  = 7;   // parity byte count, up to 65

  typedef enum logic [1:0] {
    ST_CLEAN   = 2'b00,
    ST_FIXABLE = 2'b01,
    ST_FATAL   = 2'b10,
    ST_RSVD    = 2'b11
  } dec_status_e;

  function automatic logic [CNT_W-1:0] eff_strength(input logic [CNT_W-1:0] sel);
    case (sel)
      6'd8, 6'd16, 6'd24, 6'd40: return sel;
      default:                   return 6'd16;
    endcase
  endfunction

  function automatic logic [PLEN_W-1:0] parity_len(input logic [CNT_W-1:0] t);
    return PLEN_W'(13 * int'(t >> 3));
  endfunction

  function automatic logic [POS_W-1:0] pick_pos(input logic [31:0] w, input logic upper);
    return upper ? w[HI_LSB +: POS_W] : w[POS_W-1:0];
  endfunction

  function automatic logic [7:0] bit_mask(input logic [2:0] b);
    return 8'd1 << b;
  endfunction

endpackage

// File: rtl/bchfix_strength.sv
module bchfix_strength
  import bchfix_pkg::*;
(
  input  logic [CNT_W-1:0]  t_sel,
  output logic [CNT_W-1:0]  t_eff,
  output logic [PLEN_W-1:0] p_len
);
  always_comb begin
    t_eff = eff_strength(t_sel);
    p_len = parity_len(t_eff);
  end
endmodule

// File: rtl/bchfix_seq.sv
module bchfix_seq
  import bchfix_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       status,
  input  logic [CNT_W-1:0] err_cnt,
  input  logic [CNT_W-1:0] t_eff,
  output logic             accept,
  output logic             run,
  output logic [CNT_W-1:0] step_idx,
  output logic             done,
  output logic             fail
);
  logic [CNT_W-1:0] n_q;
  logic [CNT_W-1:0] n_eff;
  logic             last_step;
  logic             fixable;
  logic             fatal;

  always_comb begin
    n_eff     = (err_cnt > t_eff) ? t_eff : err_cnt;
    accept    = start && !run;
    fixable   = (status == ST_FIXABLE);
    fatal     = (status == ST_FATAL) || (status == ST_RSVD);
    last_step = run && (step_idx == n_q - CNT_W'(1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run      <= 1'b0;
      step_idx <= '0;
      n_q      <= '0;
      done     <= 1'b0;
      fail     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        fail     <= fatal;
        step_idx <= '0;
        n_q      <= n_eff;
        if (fixable && (n_eff != '0)) run  <= 1'b1;
        else                          done <= 1'b1;
      end else if (run) begin
        step_idx <= step_idx + CNT_W'(1);
        if (last_step) begin
          run  <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/bchfix_flip.sv
module bchfix_flip
  import bchfix_pkg::*;
#(
  parameter int UNIT_BYTES = 512,
  localparam int ADDR_W    = $clog2(UNIT_BYTES)
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              run,
  input  logic [CNT_W-1:0]  step_idx,
  output logic [WIDX_W-1:0] loc_idx,
  input  logic [31:0]       loc_word,
  output logic [ADDR_W-1:0] buf_addr,
  input  logic [7:0]        buf_rdata,
  output logic              buf_we,
  output logic [7:0]        buf_wdata,
  output logic [CNT_W-1:0]  flip_cnt
);
  localparam int BYTE_IX_W = POS_W - 3;

  logic [POS_W-1:0]     pos;
  logic [BYTE_IX_W-1:0] byte_ix;
  logic                 in_unit;

  always_comb begin
    loc_idx = step_idx[CNT_W-1:1];
    pos     = pick_pos(loc_word, step_idx[0]);
    byte_ix = pos[POS_W-1:3];
  end

  generate
    if (UNIT_BYTES >= (1 << BYTE_IX_W)) begin : g_full
      assign in_unit = 1'b1;
    end else begin : g_part
      assign in_unit = (32'(byte_ix) < UNIT_BYTES);
    end
  endgenerate

  always_comb begin
    buf_addr  = byte_ix[ADDR_W-1:0];
    buf_we    = run && in_unit;
    buf_wdata = buf_rdata ^ bit_mask(pos[2:0]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      flip_cnt <= '0;
    else if (clear)  flip_cnt <= '0;
    else if (buf_we) flip_cnt <= flip_cnt + CNT_W'(1);
  end
endmodule

// File: rtl/bch_bit_fixer.sv
module bch_bit_fixer
  import bchfix_pkg::*;
#(
  parameter int UNIT_BYTES = 512,
  localparam int ADDR_W    = $clog2(UNIT_BYTES)
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        dec_status,
  input  logic [CNT_W-1:0]  err_count,
  input  logic [CNT_W-1:0]  t_sel,
  output logic [WIDX_W-1:0] loc_idx,
  input  logic [31:0]       loc_word,
  output logic [ADDR_W-1:0] buf_addr,
  input  logic [7:0]        buf_rdata,
  output logic              buf_we,
  output logic [7:0]        buf_wdata,
  output logic              busy,
  output logic              done,
  output logic              uncorrectable,
  output logic [CNT_W-1:0]  flip_count,
  output logic [PLEN_W-1:0] parity_bytes
);
  logic [CNT_W-1:0] t_eff;
  logic             accept;
  logic [CNT_W-1:0] step_idx;

  bchfix_strength u_strength (
    .t_sel (t_sel),
    .t_eff (t_eff),
    .p_len (parity_bytes)
  );

  bchfix_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .status   (dec_status),
    .err_cnt  (err_count),
    .t_eff    (t_eff),
    .accept   (accept),
    .run      (busy),
    .step_idx (step_idx),
    .done     (done),
    .fail     (uncorrectable)
  );

  bchfix_flip #(.UNIT_BYTES(UNIT_BYTES)) u_flip (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (accept),
    .run       (busy),
    .step_idx  (step_idx),
    .loc_idx   (loc_idx),
    .loc_word  (loc_word),
    .buf_addr  (buf_addr),
    .buf_rdata (buf_rdata),
    .buf_we    (buf_we),
    .buf_wdata (buf_wdata),
    .flip_cnt  (flip_count)
  );
endmodule

// File: rtl/bch_bit_fixer_chk.sv
module bch_bit_fixer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       buf_we,
  input logic [7:0] buf_rdata,
  input logic [7:0] buf_wdata,
  input logic       done,
  input logic       uncorrectable,
  input logic [5:0] flip_count
);
  AST_WRITE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |-> busy); // R2
  AST_SINGLE_BIT_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |-> ($countones(buf_wdata ^ buf_rdata) == 1)); // R3
  AST_FATAL_NO_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
    (done && uncorrectable) |-> (flip_count == 6'd0)); // R8
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_BUSY_END_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done); // R9
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (flip_count <= 6'd40)); // R6
endmodule

bind bch_bit_fixer bch_bit_fixer_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .busy          (busy),
  .buf_we        (buf_we),
  .buf_rdata     (buf_rdata),
  .buf_wdata     (buf_wdata),
  .done          (done),
  .uncorrectable (uncorrectable),
  .flip_count    (flip_count)
);

// File: tb/tb_bch_bit_fixer.sv
module tb_bch_bit_fixer;
  localparam int UB = 64;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [1:0] dec_status = 2'b00;
  logic [5:0] err_count = '0;
  logic [5:0] t_sel = 6'd16;
  logic [4:0] loc_idx;
  logic [31:0] loc_word;
  logic [5:0] buf_addr;
  logic [7:0] buf_rdata;
  logic       buf_we;
  logic [7:0] buf_wdata;
  logic       busy, done, uncorrectable;
  logic [5:0] flip_count;
  logic [6:0] parity_bytes;

  logic [31:0] locw [0:19];
  logic [7:0]  dmem [0:UB-1];
  logic [7:0]  gold [0:UB-1];
  int nchk = 0;
  int nerr = 0;
  int unsigned seed = 32'h1234_5678;

  always #2 clk = ~clk;

  bch_bit_fixer #(.UNIT_BYTES(UB)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .dec_status(dec_status),
    .err_count(err_count), .t_sel(t_sel), .loc_idx(loc_idx), .loc_word(loc_word),
    .buf_addr(buf_addr), .buf_rdata(buf_rdata), .buf_we(buf_we), .buf_wdata(buf_wdata),
    .busy(busy), .done(done), .uncorrectable(uncorrectable),
    .flip_count(flip_count), .parity_bytes(parity_bytes)
  );

  assign loc_word  = (loc_idx < 5'd20) ? locw[loc_idx] : 32'h0;
  assign buf_rdata = dmem[buf_addr];

  always @(posedge clk) if (buf_we) dmem[buf_addr] <= buf_wdata;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int unsigned rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed >> 8;
  endfunction

  // junk set in bits 31:29 and 15:13 must be ignored (R2)
  task automatic fill_locs(input int odd_hi_pos);
    for (int k = 0; k < 20; k++) begin
      int unsigned lo = rnd() % 768;
      int unsigned hi = rnd() % 8192;
      locw[k] = {3'b111, 13'(hi), 3'b101, 13'(lo)};
    end
    if (odd_hi_pos >= 0)
      for (int k = 0; k < 20; k++) locw[k][28:16] = 13'(odd_hi_pos + k);
  endtask

  task automatic run_case(input logic [1:0] st, input int n, input int tsel, input bit poke);
    int teff, ne, flips, bad;
    int qwe[$];
    int qad[$];
    teff  = (tsel == 8 || tsel == 16 || tsel == 24 || tsel == 40) ? tsel : 16;
    ne    = (n > teff) ? teff : n;
    flips = 0;
    if (st == 2'b01) begin
      for (int h = 0; h < ne; h++) begin
        int unsigned w = locw[h / 2];
        int unsigned p = (h % 2 == 1) ? ((w >> 16) & 8191) : (w & 8191);
        if (p / 8 < UB) begin
          qwe.push_back(1); qad.push_back(p / 8);
          gold[p / 8] = gold[p / 8] ^ 8'(1 << (p % 8));
          flips++;
        end else begin
          qwe.push_back(0); qad.push_back(0);
        end
      end
    end
    @(negedge clk);
    start = 1'b1; dec_status = st; err_count = 6'(n); t_sel = 6'(tsel);
    #1 chk(parity_bytes == 7'(13 * (teff / 8)), "R7 parity", parity_bytes, 13 * (teff / 8));
    @(negedge clk);
    start = 1'b0;
    if (st == 2'b01 && ne > 0) begin
      for (int i = 0; i < ne; i++) begin
        chk(buf_we == qwe[i][0], "R4 write enable per step", buf_we, qwe[i]);
        if (qwe[i] == 1) chk(buf_addr == 6'(qad[i]), "R3 byte address", buf_addr, qad[i]);
        chk(busy && !done, "R9 busy during steps", {busy, done}, 2);
        if (poke && i == 2) begin start = 1'b1; dec_status = 2'b10; err_count = 6'd1; end
        if (poke && i == 3) start = 1'b0;
        @(negedge clk);
      end
      chk(done == 1'b1, "R9 done after last step", done, 1);
      chk(flip_count == 6'(flips), "R9 flip count", flip_count, flips);
      chk(uncorrectable == 1'b0, "R8 fixable flag", uncorrectable, 0);
    end else begin
      chk(done == 1'b1, "R8 immediate done", done, 1);
      chk(flip_count == 6'd0, "R8 zero count", flip_count, 0);
      chk(uncorrectable == (st[1] == 1'b1), "R8 verdict", uncorrectable, st[1]);
      chk(buf_we == 1'b0, "R8 no write", buf_we, 0);
    end
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R9 done pulse ends", {busy, done}, 0);
    bad = 0;
    for (int b = 0; b < UB; b++) if (dmem[b] != gold[b]) bad++;
    chk(bad == 0, "R3 R5 buffer contents", bad, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    for (int b = 0; b < UB; b++) begin
      dmem[b] = 8'(b * 7 + 3);
      gold[b] = 8'(b * 7 + 3);
    end
    repeat (3) @(negedge clk);
    chk(done == 0 && busy == 0 && buf_we == 0 && flip_count == 0, "R1 reset state",
        {done, busy, buf_we}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(done == 0 && busy == 0 && flip_count == 0, "R1 idle after reset", {done, busy}, 0);

    fill_locs(-1);  run_case(2'b01, 6, 16, 1'b0);   // R2 R3 R4
    fill_locs(40);  run_case(2'b01, 5, 16, 1'b0);   // R5 odd count, in-range upper half
    fill_locs(100); run_case(2'b01, 7, 24, 1'b0);   // R5
    fill_locs(-1);  run_case(2'b00, 3, 16, 1'b0);   // R8 clean
    fill_locs(-1);  run_case(2'b10, 3, 16, 1'b0);   // R8 fatal
    fill_locs(-1);  run_case(2'b11, 4, 16, 1'b0);   // R8 reserved
    fill_locs(-1);  run_case(2'b01, 0, 16, 1'b0);   // R9 zero errors
    fill_locs(-1);  run_case(2'b01, 30, 5, 1'b0);   // R6 fallback to 16
    fill_locs(-1);  run_case(2'b01, 40, 40, 1'b0);  // R6 full strength
    fill_locs(-1);  run_case(2'b01, 12, 8, 1'b0);   // R6 clamp to 8
    fill_locs(-1);  run_case(2'b01, 24, 24, 1'b0);  // R7 24
    fill_locs(-1);  run_case(2'b01, 9, 16, 1'b1);   // R10 start while busy
    for (int r = 0; r < 6; r++) begin
      fill_locs(-1); run_case(2'b01, 1 + int'(rnd() % 40), 40, 1'b0);
    end
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule